// File: doc/BRIEF.md
# Seconds Timer with Button Interrupt

This peripheral divides the system clock down to a once-per-second event. It also watches a mechanical push-button and turns each clean press into a second event. The raw button input is brought into the clock domain by a two-stage synchroniser. A stability counter then accepts a new level only after it has held for a set number of milliseconds. Both events share one interrupt line. A small register window lets the processor find out which event fired and acknowledge it.

The processor reads the cause register to learn which sources are pending. That read also acknowledges every pending source. Software can instead acknowledge selected sources by writing ones to the same register. A second register holds an enable mask, which decides which pending sources drive the interrupt line. If a fresh event arrives in the same cycle as an acknowledge, the event is kept, so no second or press is lost.

Top module: `sec_irq_timer`

## Requirements
- R1: During and straight after reset, the cause register (address 0) and the enable mask (address 1) read as zero and `irq` is low.
- R2: Cause bit 0 is set on clock edge number `CLK_HZ` after reset release and then on every further `CLK_HZ`-th edge. It never becomes set on any other edge.
- R3: A rising level on `btn_raw` that is held for at least `DB_CYC = CLK_HZ/1000*DEBOUNCE_MS` cycles sets cause bit 1. It is set on edge `DB_CYC+2`, counted from the first edge that samples the new level. Shorter pulses, and chatter whose high stretches are each shorter than `DB_CYC`, leave bit 1 clear.
- R4: Only a debounced press sets cause bit 1. A debounced release does not set it, and neither does a button that stays held.
- R5: A write to address 0 clears each cause bit whose `wdata` bit is 1 (bit 0 for the tick, bit 1 for the press). Cause bits written with 0 are unchanged.
- R6: `rdata` shows the addressed register in bits [1:0], with all upper bits zero, whether or not `rd_en` is high. A cycle with `rd_en` high at address 0 clears all cause bits on that edge.
- R7: An event that occurs on the same edge as a clear, whether from a write or from a read, leaves its cause bit set.
- R8: Address 1 is a read/write enable mask in bits [1:0]. `irq` is high exactly when some cause bit is set and its mask bit is 1.
- R9: Addresses 2 and 3 read as zero. Writes and reads there leave the mask and the cause bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_raw | input | 1 | Unsynchronised push-button level, high when pressed |
| rd_en | input | 1 | Read strobe; at address 0 it acknowledges all causes |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address (0 cause, 1 mask) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data of the addressed register |
| irq | output | 1 | Interrupt request, pending causes gated by the mask |

## Verification
The bench builds the block with `CLK_HZ` = 2000 and `DEBOUNCE_MS` = 4. This gives a 2000-cycle second and an 8-cycle debounce window. With these values the bench can cover several whole seconds, and it can try every button pulse width from one cycle to just past the acceptance threshold. It also times the press edge cycle by cycle, and it places acknowledges exactly on the edges where a tick fires.

// File: rtl/sec_irq_timer.sv
module sec_irq_timer #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned DEBOUNCE_MS = 20,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_raw,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int unsigned DB_RAW = CLK_HZ / 1000 * DEBOUNCE_MS;
  localparam int unsigned DB_CYC = (DB_RAW > 0) ? DB_RAW : 1;
  localparam int unsigned SW     = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam int unsigned DW     = $clog2(DB_CYC + 1);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(1);

  logic [SW-1:0] sec_cnt;
  logic          sec_hit;
  assign sec_hit = (sec_cnt == SW'(CLK_HZ - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)       sec_cnt <= '0;
    else if (sec_hit) sec_cnt <= '0;
    else              sec_cnt <= sec_cnt + 1'b1;
  end

  logic [1:0]    btn_sync;
  logic          btn_db;
  logic [DW-1:0] db_cnt;
  logic          differ, db_done, press;

  assign differ  = btn_sync[1] ^ btn_db;
  assign db_done = differ && (db_cnt == DW'(DB_CYC - 1));
  assign press   = db_done && btn_sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      btn_sync <= '0;
      btn_db   <= 1'b0;
      db_cnt   <= '0;
    end else begin
      btn_sync <= {btn_sync[0], btn_raw};
      if (!differ) begin
        db_cnt <= '0;
      end else if (db_done) begin
        db_cnt <= '0;
        btn_db <= btn_sync[1];
      end else begin
        db_cnt <= db_cnt + 1'b1;
      end
    end
  end

  logic [1:0] cause, mask, set_v, clr_v;
  logic       sel_cause, sel_mask;

  assign sel_cause = (addr == A_CAUSE);
  assign sel_mask  = (addr == A_MASK);
  assign set_v     = {press, sec_hit};
  assign clr_v     = ((wr_en && sel_cause) ? wdata[1:0] : 2'b00)
                   | ((rd_en && sel_cause) ? 2'b11 : 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause <= '0;
      mask  <= '0;
    end else begin
      cause <= (cause & ~clr_v) | set_v;
      if (wr_en && sel_mask) mask <= wdata[1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_cause)     rdata[1:0] = cause;
    else if (sel_mask) rdata[1:0] = mask;
  end

  assign irq = |(cause & mask);

  logic unused_wdata;
  assign unused_wdata = &{1'b0, wdata[DATA_W-1:2]};
endmodule

module sec_irq_timer_chk #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        wd,
  input logic [1:0]        cause,
  input logic [1:0]        mask,
  input logic              btn_s,
  input logic              btn_db,
  input logic              irq
);
  int unsigned cyc;
  always_ff @(posedge clk) begin
    if (!rst_n)                cyc <= 0;
    else if (cyc == CLK_HZ - 1) cyc <= 0;
    else                       cyc <= cyc + 1;
  end

  // R2
  tick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CLK_HZ - 1) |=> cause[0]);

  // R2
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause[0] && !$past(cause[0])) |-> (cyc == 0));

  // R7
  clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && wd[0] && cyc == CLK_HZ - 1) |=> cause[0]);

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && addr == '0 && wd[1]) |=> (!cause[1] || $rose(btn_db)));

  // R6
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == '0 && cyc != CLK_HZ - 1) |=> (!cause[0] && (!cause[1] || $rose(btn_db))));

  // R4
  press_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause[1] && !$past(cause[1])) |-> $rose(btn_db));

  // R3
  db_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_db != $past(btn_db)) |-> (btn_db == $past(btn_s)));

  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 2'b00) |-> !irq);
endmodule

bind sec_irq_timer sec_irq_timer_chk #(.CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wd(wdata[1:0]), .cause(cause), .mask(mask), .btn_s(btn_sync[1]),
  .btn_db(btn_db), .irq(irq)
);

// File: tb/sim_sec_irq_timer.sv
module sim_sec_irq_timer;
  localparam int CLK_HZ = 2000;
  localparam int DEB_MS = 4;
  localparam int DB     = CLK_HZ / 1000 * DEB_MS;

  logic        clk = 1'b0;
  logic        rst_n, btn_raw, rd_en, wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;

  always #5 clk = ~clk;

  sec_irq_timer #(.CLK_HZ(CLK_HZ), .DEBOUNCE_MS(DEB_MS), .DATA_W(32), .ADDR_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int ecount;
  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, ecount);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_edge(input int n);
    while (ecount < n) step(1);
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    addr = a; rd_en = 0; wr_en = 0;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    step(1);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; rd_en = 1;
    #1 d = rdata;
    step(1);
    rd_en = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(190000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; btn_raw = 0; rd_en = 0; wr_en = 0; addr = 0; wdata = 0;
    step(3);
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    peek(0, d); check("R1 cause", d, 0);
    peek(1, d); check("R1 mask", d, 0);
    step(1);
    rst_n = 1;

    // R2 first second
    wait_edge(CLK_HZ - 1);
    peek(0, d); check("R2 before first tick", d, 0);
    step(1);
    peek(0, d); check("R2 first tick", d, 1);
    check("R8 masked irq", {31'b0, irq}, 0);

    // R8 mask
    wr(1, 32'h1);
    peek(1, d); check("R8 mask readback", d, 1);
    check("R8 irq enabled", {31'b0, irq}, 1);

    // R6 read clears
    rd(0, d); check("R6 read value", d, 1);
    peek(0, d); check("R6 cleared by read", d, 0);
    check("R6 irq dropped", {31'b0, irq}, 0);

    // R2 further periods
    for (int p = 2; p <= 4; p++) begin
      wait_edge(p * CLK_HZ - 1);
      peek(0, d); check("R2 before tick", d, 0);
      step(1);
      peek(0, d); check("R2 periodic tick", d, 1);
      check("R8 irq on tick", {31'b0, irq}, 1);
      wr(0, 32'h1);
      peek(0, d); check("R5 w1c tick", d, 0);
    end

    // R5 selective clear
    wait_edge(5 * CLK_HZ);
    peek(0, d); check("R2 fifth tick", d, 1);
    wr(0, 32'h2);
    peek(0, d); check("R5 zero bit kept", d, 1);
    wr(0, 32'hFFFF_FFFD);
    peek(0, d); check("R5 one bit cleared", d, 0);

    // R7 clear racing a tick
    wait_edge(6 * CLK_HZ - 1);
    wr(0, 32'h1);
    peek(0, d); check("R7 write race", d, 1);
    wait_edge(7 * CLK_HZ - 1);
    rd(0, d); check("R6 read before race", d, 1);
    peek(0, d); check("R7 read race", d[0], 1);
    wr(0, 32'h3);

    // R3 / R4 pulse width sweep
    for (int w = 1; w <= DB + 2; w++) begin
      wr(0, 32'h2);
      btn_raw = 1;
      step(w);
      btn_raw = 0;
      step(DB + 8);
      peek(0, d);
      check((w >= DB) ? "R3 long pulse" : "R4 short pulse", d[1], (w >= DB) ? 1 : 0);
    end

    // R3 exact acceptance edge
    wr(0, 32'h2);
    btn_raw = 1;
    step(DB + 1);
    peek(0, d); check("R3 before accept edge", d[1], 0);
    step(1);
    peek(0, d); check("R3 accept edge", d[1], 1);
    wr(0, 32'h2);
    step(20);
    peek(0, d); check("R4 held no retrigger", d[1], 0);
    btn_raw = 0;
    step(DB + 8);
    peek(0, d); check("R4 release ignored", d[1], 0);

    // R3 chatter then steady
    for (int k = 0; k < 3; k++) begin
      btn_raw = 1; step(DB - 2);
      btn_raw = 0; step(2);
    end
    peek(0, d); check("R3 chatter rejected", d[1], 0);
    btn_raw = 1; step(DB + 4);
    peek(0, d); check("R3 steady after chatter", d[1], 1);
    btn_raw = 0; step(DB + 8);

    // R8 press gated by mask
    wr(0, 32'h3);
    wr(1, 32'h2);
    check("R8 irq idle", {31'b0, irq}, 0);
    btn_raw = 1; step(DB + 4);
    check("R8 irq on press", {31'b0, irq}, 1);
    wr(1, 32'h0);
    check("R8 irq masked off", {31'b0, irq}, 0);
    wr(1, 32'h2);
    check("R8 irq re-enabled", {31'b0, irq}, 1);

    // R9 unmapped addresses
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    peek(2, d); check("R9 addr2 zero", d, 0);
    peek(3, d); check("R9 addr3 zero", d, 0);
    peek(1, d); check("R9 mask untouched", d, 2);
    rd(2, d);
    peek(0, d); check("R9 cause untouched", d[1], 1);
    btn_raw = 0;
    step(DB + 8);

    finish_run();
  end
endmodule